// File: doc/BRIEF.md
# Auto-Increment Indirect Memory Port

This block gives a CPU access to a private display memory without a direct bus. The CPU sees four byte-wide registers: a status register, two registers that together hold a 16-bit memory pointer, and a data window. The CPU selects a register with a 2-bit select and strobes it for a read or a write.

The data window always holds a prefetched copy of the byte at the pointer. Loading the low pointer byte fetches that location. Reading the window returns the prefetched byte, steps the pointer forward and fetches the next byte. Writing the window stores the byte at the pointer, steps the pointer forward and fetches the new location. A CPU can therefore stream through memory in either direction of transfer without reloading the pointer.

On the memory side, the block raises a request that an external arbiter grants. The arbiter models display refresh. The status ready bit tells the CPU when the pending memory work is done.

Top module: `iamp_top`

## Requirements
- R1: After synchronous reset the pointer is 0x0000, no memory request is raised and status bit 7 (ready) is 1.
- R2: Register select encoding is 0 = status, 1 = pointer high byte, 2 = pointer low byte, 3 = data window. All four registers can be read back. Status bits other than bit 7 read 0. Writing select 1 changes only the high byte and starts no memory cycle, so ready stays 1.
- R3: Writing select 2 loads the low byte and starts a read of the full pointer. Ready reads 0 in the cycle after the write and returns to 1 once the fetched byte is in the data window. No request is raised while ready is 1.
- R4: A CPU read of select 3 returns the data window, advances the pointer by one and refills the window from the new pointer.
- R5: A CPU write of select 3 stores the byte at the current pointer, advances the pointer by one and refills the window from the new location before ready returns to 1.
- R6: For a data write, the memory sees a granted write at the old pointer, and then a read request for the next address.
- R7: Advancing the pointer from 0xFFFF gives 0x0000.
- R8: A memory cycle completes only on a cycle where the grant input is high. While the grant is low, the request, address and direction are held and ready stays 0. Read data is taken from the memory one cycle after the read was granted.
- R9: Writes to selects 1–3 and reads of select 3 that occur while ready is 0 are ignored. They leave the pointer, the data window and the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 2 | Register select |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe (side effect only on select 3) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Selected register contents |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_gnt | input | 1 | Grant; the request completes on a cycle where this is high |
| mem_rdata | input | 8 | Memory read data, valid one cycle after a granted read |

## Verification
The pointer/window function is first driven with directed sequences. These cover a bare high-byte load, a low-byte load with a permanent grant, streams of window reads and of window writes, and pointer loads at 0xFFFF. Together they separate the prefetch, the increment and the wrap from one another. Runs with the grant held low, and with strobes issued while busy, show whether the block stalls correctly and whether it lets busy-time accesses leak into the pointer, window or memory. A long mix of random reads, writes and pointer loads under a randomly toggling grant then checks that ordering and refill stay correct when memory cycles stretch by arbitrary amounts.

// File: rtl/iamp_pkg.sv
package iamp_pkg;

    typedef enum logic [1:0] {
        SEL_STATUS  = 2'd0,
        SEL_PTR_HI  = 2'd1,
        SEL_PTR_LO  = 2'd2,
        SEL_WINDOW  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_STORE = 2'd1,
        SEQ_FETCH = 2'd2,
        SEQ_FILL  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic load_hi;
        logic load_lo;
        logic win_rd;
        logic win_wr;
    } cpu_op_t;

    localparam int READY_BIT = 7;

    function automatic logic [15:0] ptr_step(input logic [15:0] p);
        return p + 16'd1;
    endfunction

endpackage

// File: rtl/iamp_cpu_decode.sv
module iamp_cpu_decode
    import iamp_pkg::*;
(
    input  logic        cpu_wr,
    input  logic        cpu_rd,
    input  logic [1:0]  cpu_sel,
    input  logic        ready,
    output cpu_op_t     op
);
    cpu_op_t raw;

    always_comb begin
        raw = '0;
        unique case (reg_sel_e'(cpu_sel))
            SEL_PTR_HI: raw.load_hi = cpu_wr;
            SEL_PTR_LO: raw.load_lo = cpu_wr;
            SEL_WINDOW: begin
                raw.win_wr = cpu_wr;
                raw.win_rd = cpu_rd & ~cpu_wr;
            end
            default: raw = '0;
        endcase
        op = ready ? raw : '0;
    end
endmodule

// File: rtl/iamp_ptr_reg.sv
module iamp_ptr_reg #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_hi,
    input  logic              load_lo,
    input  logic              step,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] ptr
);
    localparam int HI_W = ADDR_W - DATA_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load_hi) begin
            ptr[ADDR_W-1:DATA_W] <= wdata[HI_W-1:0];
        end else if (load_lo) begin
            ptr[DATA_W-1:0] <= wdata;
        end else if (step) begin
            ptr <= ptr + ADDR_W'(1);
        end
    end

    p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (step && !load_hi && !load_lo && ptr == '1) |=> ptr == '0)
        else $error("pointer did not wrap");

    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (step && !load_hi && !load_lo) |=> ptr == $past(ptr) + ADDR_W'(1))
        else $error("pointer did not advance");
endmodule

// File: rtl/iamp_mem_seq.sv
module iamp_mem_seq
    import iamp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_fetch,
    input  logic              start_store,
    input  logic [DATA_W-1:0] store_data,
    input  logic [ADDR_W-1:0] ptr,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              step,
    output logic              ready,
    output logic [DATA_W-1:0] window
);
    seq_state_e state, state_n;
    logic [DATA_W-1:0] store_q;

    always_comb begin
        state_n = state;
        step    = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                if (start_store)      state_n = SEQ_STORE;
                else if (start_fetch) state_n = SEQ_FETCH;
            end
            SEQ_STORE: if (mem_gnt) begin
                state_n = SEQ_FETCH;
                step    = 1'b1;
            end
            SEQ_FETCH: if (mem_gnt) state_n = SEQ_FILL;
            SEQ_FILL:  state_n = SEQ_IDLE;
            default:   state_n = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            store_q <= '0;
            window  <= '0;
        end else begin
            state <= state_n;
            if (state == SEQ_IDLE && start_store) store_q <= store_data;
            if (state == SEQ_FILL) window <= mem_rdata;
        end
    end

    assign mem_req   = (state == SEQ_STORE) || (state == SEQ_FETCH);
    assign mem_we    = (state == SEQ_STORE);
    assign mem_addr  = ptr;
    assign mem_wdata = store_q;
    assign ready     = (state == SEQ_IDLE);

    p_quiet_ready_r3: assert property (@(posedge clk) disable iff (rst)
        ready |-> !mem_req)
        else $error("request raised while ready");

    p_hold_no_grant_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && !ready)
        else $error("request dropped or changed without grant");

    p_store_then_fetch_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_gnt) |=> mem_req && !mem_we && mem_addr == $past(mem_addr) + ADDR_W'(1))
        else $error("store not followed by fetch of next address");
endmodule

// File: rtl/iamp_top.sv
module iamp_top
    import iamp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cpu_sel,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int HI_W = ADDR_W - DATA_W;

    cpu_op_t           op;
    logic              ready;
    logic              seq_step;
    logic [ADDR_W-1:0] ptr;
    logic [DATA_W-1:0] window;

    iamp_cpu_decode u_dec (
        .cpu_wr  (cpu_wr),
        .cpu_rd  (cpu_rd),
        .cpu_sel (cpu_sel),
        .ready   (ready),
        .op      (op)
    );

    iamp_ptr_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .load_hi (op.load_hi),
        .load_lo (op.load_lo),
        .step    (op.win_rd | seq_step),
        .wdata   (cpu_wdata),
        .ptr     (ptr)
    );

    iamp_mem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_fetch (op.load_lo | op.win_rd),
        .start_store (op.win_wr),
        .store_data  (cpu_wdata),
        .ptr         (ptr),
        .mem_gnt     (mem_gnt),
        .mem_rdata   (mem_rdata),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .step        (seq_step),
        .ready       (ready),
        .window      (window)
    );

    always_comb begin
        cpu_rdata = '0;
        unique case (reg_sel_e'(cpu_sel))
            SEL_STATUS: cpu_rdata[READY_BIT] = ready;
            SEL_PTR_HI: cpu_rdata[HI_W-1:0]  = ptr[ADDR_W-1:DATA_W];
            SEL_PTR_LO: cpu_rdata            = ptr[DATA_W-1:0];
            SEL_WINDOW: cpu_rdata            = window;
            default:    cpu_rdata            = '0;
        endcase
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> ready && ptr == '0 && !mem_req)
        else $error("reset state wrong");

    p_busy_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (!ready && !(mem_req && mem_we && mem_gnt)) |=> $stable(ptr))
        else $error("pointer moved while busy");

    p_hi_no_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        (ready && cpu_wr && cpu_sel == 2'd1) |=> ready)
        else $error("high-byte load started a cycle");
endmodule

// File: tb/iamp_top_test.sv
module iamp_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cpu_sel = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_gnt = 1'b1;
    logic [7:0]  mem_rdata = '0;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    int gnt_mode = 1;          // 0 random, 1 high, 2 low
    logic [7:0]  mem [256];
    logic [7:0]  ref_mem [256];
    logic [15:0] exp_ptr;
    logic [7:0]  exp_win;
    logic        prev_we, last_we;
    logic [15:0] prev_a, last_a;

    always #2.5 clk = ~clk;

    iamp_top uut (.*);

    always @(posedge clk) begin
        if (mem_req && mem_gnt) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[7:0]];
            prev_we <= last_we; prev_a <= last_a;
            last_we <= mem_we;  last_a <= mem_addr;
        end
    end

    always @(negedge clk) begin
        case (gnt_mode)
            0: mem_gnt = ($urandom % 10) < 6;
            1: mem_gnt = 1'b1;
            default: mem_gnt = 1'b0;
        endcase
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk); cpu_sel = s; cpu_wr = 1'b1; cpu_wdata = d;
        @(negedge clk); cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk); cpu_sel = s; cpu_rd = 1'b1; #1 v = cpu_rdata;
        @(negedge clk); cpu_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] s, output logic [7:0] v);
        cpu_sel = s; #1 v = cpu_rdata;
    endtask

    task automatic wait_ready(input string req);
        logic [7:0] v;
        int n = 0;
        peek(2'd0, v);
        while (!v[7] && n < 500) begin
            @(negedge clk); peek(2'd0, v); n++;
        end
        chk(v[7], req, {24'd0, v}, 32'h80);
    endtask

    task automatic check_state(input string req);
        logic [7:0] h, l, w;
        @(negedge clk);
        peek(2'd1, h); peek(2'd2, l); peek(2'd3, w);
        chk({h, l} == exp_ptr, req, {16'd0, h, l}, {16'd0, exp_ptr});
        chk(w == exp_win, req, {24'd0, w}, {24'd0, exp_win});
    endtask

    task automatic set_ptr(input logic [15:0] a);
        wr(2'd1, a[15:8]);
        wr(2'd2, a[7:0]);
        exp_ptr = a;
        wait_ready("R3");
        exp_win = ref_mem[exp_ptr[7:0]];
    endtask

    task automatic win_read(input string req);
        logic [7:0] v;
        rd(2'd3, v);
        chk(v == exp_win, req, {24'd0, v}, {24'd0, exp_win});
        exp_ptr = exp_ptr + 16'd1;
        wait_ready(req);
        exp_win = ref_mem[exp_ptr[7:0]];
    endtask

    task automatic win_write(input logic [7:0] d, input string req);
        logic [15:0] a = exp_ptr;
        wr(2'd3, d);
        ref_mem[a[7:0]] = d;
        exp_ptr = exp_ptr + 16'd1;
        wait_ready(req);
        exp_win = ref_mem[exp_ptr[7:0]];
        chk(mem[a[7:0]] == d, req, {24'd0, mem[a[7:0]]}, {24'd0, d});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h1C0DE));
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 37 + 5);
            ref_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        peek(2'd0, v); chk(v == 8'h80, "R1", {24'd0, v}, 32'h80);
        chk(mem_req == 1'b0, "R1", {31'd0, mem_req}, 32'd0);
        exp_ptr = 16'h0000; exp_win = 8'h00;
        check_state("R1");

        // R2: high byte load alone
        wr(2'd1, 8'h12);
        peek(2'd0, v); chk(v == 8'h80, "R2", {24'd0, v}, 32'h80);
        exp_ptr = 16'h1200;
        check_state("R2");

        // R3: low byte load prefetches
        wr(2'd2, 8'h34);
        peek(2'd0, v); chk(v == 8'h00, "R3", {24'd0, v}, 32'h00);
        exp_ptr = 16'h1234;
        wait_ready("R3");
        exp_win = ref_mem[8'h34];
        check_state("R3");

        // R4: streaming reads
        for (int i = 0; i < 5; i++) win_read("R4");
        check_state("R4");

        // R5 / R6: streaming writes
        for (int i = 0; i < 4; i++) win_write(8'($urandom), "R5");
        check_state("R5");
        chk(prev_we == 1'b1 && last_we == 1'b0, "R6", {30'd0, prev_we, last_we}, 32'h2);
        chk(last_a == prev_a + 16'd1, "R6", {16'd0, last_a}, {16'd0, prev_a + 16'd1});

        // R7: wrap on read and on write
        set_ptr(16'hFFFF);
        win_read("R7");
        chk(exp_ptr == 16'h0000, "R7", {16'd0, exp_ptr}, 32'd0);
        check_state("R7");
        set_ptr(16'hFFFF);
        win_write(8'hA5, "R7");
        check_state("R7");

        // R8: no progress without grant
        gnt_mode = 2;
        @(negedge clk);
        wr(2'd2, 8'h40);
        repeat (20) @(negedge clk);
        peek(2'd0, v); chk(v == 8'h00, "R8", {24'd0, v}, 32'h00);
        chk(mem_req && !mem_we && mem_addr == 16'h0040, "R8", {15'd0, mem_req, mem_addr}, 32'h10040);

        // R9: strobes while busy are ignored
        wr(2'd1, 8'h77);
        wr(2'd2, 8'h99);
        wr(2'd3, 8'h5A);
        rd(2'd3, v);
        gnt_mode = 1;
        exp_ptr = 16'h0040;
        wait_ready("R8");
        exp_win = ref_mem[8'h40];
        check_state("R9");
        chk(mem[8'h40] == ref_mem[8'h40], "R9", {24'd0, mem[8'h40]}, {24'd0, ref_mem[8'h40]});

        // random mix under random grant (R4, R5, R8)
        gnt_mode = 0;
        for (int i = 0; i < 300; i++) begin
            int k = $urandom % 10;
            if (k < 4)       win_read("R4");
            else if (k < 8)  win_write(8'($urandom), "R5");
            else             set_ptr(16'($urandom));
        end
        check_state("R8");
        for (int i = 0; i < 256; i++)
            chk(mem[i] == ref_mem[i], "R5", {24'd0, mem[i]}, {24'd0, ref_mem[i]});

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule